// File: doc/BRIEF.md
# Quadrature Position Error Front End

This block produces the error sample that feeds a digital position controller. It follows a two-channel incremental encoder, counting every edge of either channel into a signed 32-bit position. A host processor writes a 32-bit target position. The block subtracts the measured position from that target and clamps the result into a signed 16-bit error word. The clamp keeps the controller's later arithmetic from overflowing.

The block also paces the loop. A programmable divider issues a one-cycle sample strobe. The error word is captured only on that strobe, so the controller sees one stable value per sample period. For a 1 ms loop on a 250 MHz clock, the period is set to 250000 cycles. The encoder used in the target setup gives 48 counts per motor revolution under 4x decoding.

The reference write port is a valid/ready stream. `ref_ready` is held high at all times, so the block never applies back-pressure. Every cycle with `ref_valid` high is one accepted write, and it takes effect at that clock edge. The fault flag, its clear input, the period and the strobe are plain level or pulse signals.

Top module: `qpe_front_end`

## Requirements
- R1: After reset the position is 0, the reference is 0, the error output is 0, the fault flag is 0 and the strobe is low.
- R2: With the channel pair written as {A,B}, the forward Gray order 00, 10, 11, 01, 00 adds 1 to the position for each step. A change on a pin shows on `position` three clock edges after it reaches the pin.
- R3: Stepping through the same order backwards subtracts 1 per step, and the position goes below zero in two's complement.
- R4: If both channels change within one synchronized cycle, the position stays the same and `enc_fault` is set. The new channel state then becomes the base for the next step.
- R5: `enc_fault` stays set until `fault_clr` is sampled high. If an illegal change and a clear land on the same edge, the flag ends up set.
- R6: `ref_ready` is always 1. Each cycle with `ref_valid` high loads `ref_data` as the reference.
- R7: The error is reference minus position, computed without 32-bit wrap. Any true difference above 32767, including 0x7FFFFFFF minus a negative position, gives exactly 32767.
- R8: Any true difference below -32768, including 0x80000000 minus a positive position, gives exactly -32768. The values 32767 and -32768 themselves pass through unchanged.
- R9: With `sample_period` equal to N (N >= 2), `sample_strobe` is high for one cycle in every N cycles. An N of 0 or 1 holds the strobe high on every cycle.
- R10: `pos_error` changes only on the clock edge where the strobe is high. It appears one cycle after the strobe cycle, and it holds through any reference or position change in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enc_a | input | 1 | Encoder channel A, asynchronous |
| enc_b | input | 1 | Encoder channel B, asynchronous |
| ref_valid | input | 1 | Reference write valid |
| ref_ready | output | 1 | Reference write ready, always 1 |
| ref_data | input | 32 | Reference position, two's complement |
| fault_clr | input | 1 | Clears the sticky fault flag |
| sample_period | input | 24 | Strobe period in clock cycles |
| position | output | 32 | Measured position count, two's complement |
| pos_error | output | 16 | Clamped reference minus position |
| sample_strobe | output | 1 | One-cycle loop sample strobe |
| enc_fault | output | 1 | Sticky illegal-transition flag |

## Verification
The hardest case to reach from the ports is a clear that meets an illegal double-channel change on the very edge where the decoder sees it. The pin change has to pass through the synchronizer first. The bench changes both channels, counts two edges, raises `fault_clr` for exactly the third edge, and then expects the flag to read set. The clamp's wrap cases are also hard to hit. They need a reference near the 32-bit limits while the position sits on the opposite side of zero, so the bench first walks the encoder to a negative count and then writes the extreme reference values.

// File: rtl/qpe_pkg.sv
package qpe_pkg;
  typedef enum logic [1:0] {
    STEP_HOLD = 2'd0,
    STEP_FWD  = 2'd1,
    STEP_REV  = 2'd2,
    STEP_BAD  = 2'd3
  } step_e;

  localparam int SYNC_STAGES = 2;
endpackage

// File: rtl/qpe_sync.sv
module qpe_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = qpe_pkg::SYNC_STAGES
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], din[g]};
    end
    assign dout[g] = chain[STAGES-1];
  end
endmodule

// File: rtl/qpe_quad_decoder.sv
module qpe_quad_decoder
  import qpe_pkg::*;
#(
  parameter int POS_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             a_s,
  input  logic             b_s,
  input  logic             fault_clr,
  output logic [POS_W-1:0] pos,
  output logic             fault
);
  logic  a_prev, b_prev;
  logic  a_chg, b_chg;
  step_e step;

  assign a_chg = a_prev ^ a_s;
  assign b_chg = b_prev ^ b_s;

  // Forward order {A,B}: 00 -> 10 -> 11 -> 01 -> 00
  always_comb begin
    if (a_chg && b_chg)          step = STEP_BAD;
    else if (!a_chg && !b_chg)   step = STEP_HOLD;
    else if (!(a_prev ^ b_s))    step = STEP_FWD;
    else                         step = STEP_REV;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_prev <= 1'b0;
      b_prev <= 1'b0;
      pos    <= '0;
      fault  <= 1'b0;
    end else begin
      a_prev <= a_s;
      b_prev <= b_s;
      case (step)
        STEP_FWD: pos <= pos + POS_W'(1);
        STEP_REV: pos <= pos - POS_W'(1);
        default:  pos <= pos;
      endcase
      if (step == STEP_BAD) fault <= 1'b1;
      else if (fault_clr)   fault <= 1'b0;
    end
  end

  assert_unit_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (pos == $past(pos) || pos == $past(pos) + POS_W'(1) || pos == $past(pos) - POS_W'(1)))
    else $error("position moved by more than one count");

  assert_bad_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (a_chg && b_chg) |=> ($stable(pos) && fault))
    else $error("illegal transition altered count or missed fault");

  assert_fault_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (fault && !fault_clr) |=> fault)
    else $error("fault flag dropped without clear");
endmodule

// File: rtl/qpe_sample_timer.sv
module qpe_sample_timer #(
  parameter int PER_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PER_W-1:0] period,
  output logic             tick
);
  logic [PER_W-1:0] cnt;
  logic             wrap;

  assign wrap = (period <= PER_W'(1)) || (cnt >= period - PER_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (wrap) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + PER_W'(1);
      tick <= 1'b0;
    end
  end

  assert_single_tick_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && period > PER_W'(1)) |=> !tick)
    else $error("strobe wider than one cycle");
endmodule

// File: rtl/qpe_err_clamp.sv
module qpe_err_clamp #(
  parameter int POS_W = 32,
  parameter int ERR_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [POS_W-1:0] ref_pos,
  input  logic [POS_W-1:0] meas_pos,
  output logic [ERR_W-1:0] err
);
  localparam int DW = POS_W + 1;
  localparam int UW = DW - ERR_W + 1;
  localparam logic [ERR_W-1:0] SAT_HI = {1'b0, {(ERR_W-1){1'b1}}};
  localparam logic [ERR_W-1:0] SAT_LO = {1'b1, {(ERR_W-1){1'b0}}};

  logic [DW-1:0]    diff;
  logic [UW-1:0]    upper;
  logic [ERR_W-1:0] sat;

  assign diff  = {ref_pos[POS_W-1], ref_pos} - {meas_pos[POS_W-1], meas_pos};
  assign upper = diff[DW-1:ERR_W-1];

  always_comb begin
    if (!diff[DW-1] && (upper != '0))      sat = SAT_HI;
    else if (diff[DW-1] && (upper != '1))  sat = SAT_LO;
    else                                   sat = diff[ERR_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    err <= '0;
    else if (load) err <= sat;
  end

  assert_err_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(err))
    else $error("error word changed outside a strobe");
endmodule

// File: rtl/qpe_front_end.sv
module qpe_front_end #(
  parameter int POS_W = 32,
  parameter int ERR_W = 16,
  parameter int PER_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enc_a,
  input  logic             enc_b,
  input  logic             ref_valid,
  output logic             ref_ready,
  input  logic [POS_W-1:0] ref_data,
  input  logic             fault_clr,
  input  logic [PER_W-1:0] sample_period,
  output logic [POS_W-1:0] position,
  output logic [ERR_W-1:0] pos_error,
  output logic             sample_strobe,
  output logic             enc_fault
);
  logic [1:0]       ab_s;
  logic [POS_W-1:0] ref_q;

  assign ref_ready = 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      ref_q <= '0;
    else if (ref_valid && ref_ready) ref_q <= ref_data;
  end

  qpe_sync #(.WIDTH(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .din({enc_a, enc_b}), .dout(ab_s)
  );

  qpe_quad_decoder #(.POS_W(POS_W)) u_dec (
    .clk(clk), .rst_n(rst_n), .a_s(ab_s[1]), .b_s(ab_s[0]),
    .fault_clr(fault_clr), .pos(position), .fault(enc_fault)
  );

  qpe_sample_timer #(.PER_W(PER_W)) u_tmr (
    .clk(clk), .rst_n(rst_n), .period(sample_period), .tick(sample_strobe)
  );

  qpe_err_clamp #(.POS_W(POS_W), .ERR_W(ERR_W)) u_clamp (
    .clk(clk), .rst_n(rst_n), .load(sample_strobe),
    .ref_pos(ref_q), .meas_pos(position), .err(pos_error)
  );

  assert_ref_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ref_valid |=> (ref_q == $past(ref_data)))
    else $error("reference write lost");
endmodule

// File: tb/qpe_front_end_bench.sv
module qpe_front_end_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enc_a = 1'b0, enc_b = 1'b0;
  logic        ref_valid = 1'b0;
  logic        ref_ready;
  logic [31:0] ref_data = '0;
  logic        fault_clr = 1'b0;
  logic [23:0] sample_period = 24'd8;
  logic [31:0] position;
  logic [15:0] pos_error;
  logic        sample_strobe;
  logic        enc_fault;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  qpe_front_end u_qpe_front_end (
    .clk(clk), .rst_n(rst_n), .enc_a(enc_a), .enc_b(enc_b),
    .ref_valid(ref_valid), .ref_ready(ref_ready), .ref_data(ref_data),
    .fault_clr(fault_clr), .sample_period(sample_period),
    .position(position), .pos_error(pos_error),
    .sample_strobe(sample_strobe), .enc_fault(enc_fault)
  );

  task automatic chk(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic move(logic a, logic b);
    @(negedge clk);
    enc_a = a; enc_b = b;
    repeat (4) @(negedge clk);
  endtask

  task automatic write_ref(int v);
    @(negedge clk);
    ref_valid = 1'b1; ref_data = v;
    @(negedge clk);
    ref_valid = 1'b0;
  endtask

  task automatic sample_err(output int e);
    int guard = 0;
    @(negedge clk);
    while (!sample_strobe && guard < 100) begin
      @(negedge clk);
      guard++;
    end
    @(negedge clk);
    e = $signed(pos_error);
  endtask

  task automatic t_reset;
    chk("R1 position", $signed(position), 0);
    chk("R1 error", $signed(pos_error), 0);
    chk("R1 fault", enc_fault, 0);
    chk("R1 strobe", sample_strobe, 0);
  endtask

  task automatic t_forward;
    move(1, 0);
    chk("R2 first step", $signed(position), 1);
    move(1, 1); move(0, 1); move(0, 0);
    move(1, 0); move(1, 1); move(0, 1); move(0, 0);
    chk("R2 two cycles", $signed(position), 8);
  endtask

  task automatic t_reverse;
    for (int i = 0; i < 3; i++) begin
      move(0, 1); move(1, 1); move(1, 0); move(0, 0);
    end
    chk("R3 below zero", $signed(position), -4);
  endtask

  task automatic t_illegal;
    move(1, 1);
    chk("R4 count held", $signed(position), -4);
    chk("R4 fault set", enc_fault, 1);
    move(0, 1); move(0, 0);
    chk("R4 new base", $signed(position), -2);
    chk("R5 sticky", enc_fault, 1);
    @(negedge clk); fault_clr = 1'b1;
    @(negedge clk); fault_clr = 1'b0;
    chk("R5 cleared", enc_fault, 0);
    // clear coincides with the edge that sees the double change
    @(negedge clk); enc_a = 1'b1; enc_b = 1'b1;
    @(negedge clk);
    @(negedge clk); fault_clr = 1'b1;
    @(negedge clk); fault_clr = 1'b0;
    chk("R5 set wins", enc_fault, 1);
    chk("R4 held again", $signed(position), -2);
    move(0, 1); move(0, 0);
    @(negedge clk); fault_clr = 1'b1;
    @(negedge clk); fault_clr = 1'b0;
    chk("R3 back at zero", $signed(position), 0);
  endtask

  task automatic t_error;
    int e;
    chk("R6 ready", ref_ready, 1);
    write_ref(100);     sample_err(e); chk("R6 difference", e, 100);
    write_ref(32767);   sample_err(e); chk("R8 exact top", e, 32767);
    write_ref(32768);   sample_err(e); chk("R7 clamp high", e, 32767);
    write_ref(-32768);  sample_err(e); chk("R8 exact bottom", e, -32768);
    write_ref(-32769);  sample_err(e); chk("R8 clamp low", e, -32768);
    move(0, 1); move(1, 1); move(1, 0); move(0, 0);
    chk("R3 position -4", $signed(position), -4);
    write_ref(10);      sample_err(e); chk("R6 with offset", e, 14);
    write_ref(32763);   sample_err(e); chk("R7 top with offset", e, 32767);
    write_ref(32764);   sample_err(e); chk("R7 over with offset", e, 32767);
    write_ref(32'h7fffffff); sample_err(e); chk("R7 wrap case", e, 32767);
    move(1, 0); move(1, 1); move(0, 1); move(0, 0);
    move(1, 0); move(1, 1); move(0, 1); move(0, 0);
    chk("R2 position 4", $signed(position), 4);
    write_ref(32'h80000000); sample_err(e); chk("R8 wrap case", e, -32768);
  endtask

  task automatic t_hold;
    int e;
    write_ref(50); sample_err(e);
    chk("R10 loaded", e, 46);
    ref_valid = 1'b1; ref_data = 900;
    @(negedge clk); ref_valid = 1'b0;
    for (int i = 0; i < 4; i++) begin
      chk("R10 held", $signed(pos_error), 46);
      @(negedge clk);
    end
    sample_err(e);
    chk("R10 next sample", e, 896);
  endtask

  task automatic t_strobe;
    int highs = 0, gap = 0, bad = 0;
    sample_period = 24'd5;
    repeat (20) @(negedge clk);
    while (!sample_strobe) @(negedge clk);
    for (int i = 0; i < 50; i++) begin
      if (sample_strobe) begin
        highs++;
        if (i != 0 && gap != 5) bad++;
        gap = 0;
      end
      gap++;
      @(negedge clk);
    end
    chk("R9 count in 50", highs, 10);
    chk("R9 spacing", bad, 0);
    sample_period = 24'd1;
    repeat (3) @(negedge clk);
    highs = 0;
    for (int i = 0; i < 10; i++) begin
      if (sample_strobe) highs++;
      @(negedge clk);
    end
    chk("R9 period one", highs, 10);
    sample_period = 24'd0;
    repeat (3) @(negedge clk);
    chk("R9 period zero", sample_strobe, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_forward();
    t_reverse();
    t_illegal();
    t_error();
    t_hold();
    t_strobe();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule